// File: doc/BRIEF.md
# Cluster Pair-Weight Energy Accumulator

This block forms the partial Hamiltonian energy of one three-city cluster in a digital Ising annealer for route-ordering problems. It keeps a compact weight window of P columns by 3P-1 rows, each entry an 8-bit distance. A column belongs to one starting city. Its rows hold that city's distances to cities in its own cluster and in the two neighbouring clusters.

A start pulse opens an evaluation of one spin order. On each of the next P cycles, the step counter picks the column. An 8-bit spin-derived select word marks the rows whose weights take part. Every stored bit is gated by a NOR of the active-low select line with the complemented stored bit. An 8:2 pick takes two of the gated weights, and their sum is added into the running energy. A transfer enable for the whole cluster can blank a step. A noise mask, limited to a few low bits, flips stored bits as they are read, which models the disturbance used for annealing. When the last step is done, the result is held with a valid flag. A controller runs the evaluation once for the current order and once for the swapped order, then compares the two results.

Top module: `cwe_cluster_energy`

## Requirements
- R1: After reset, `energy` is 0, `energy_vld` is 0 and every stored weight is 0.
- R2: When `ld_en` is high at a clock edge, row `ld_row` of every column c is written with `ld_data[c*8 +: 8]`. A step that runs in the same cycle still reads the old value.
- R3: When `start` is high (and `clr` is low) at an edge, the energy goes to 0 on that edge. On each of the next P = 3 edges, one step is added. `energy_vld` rises on the third of those edges.
- R4: Step k (k = 0, 1, 2) reads column k. Bit r of `sel` set to 1 selects row r. The step adds the weights of the lowest and the highest selected rows. A single selected row is added once. No selected row adds 0.
- R5: When more than two bits of `sel` are set, only the lowest and the highest selected rows count.
- R6: A step taken while `xfer_en` is 0 adds 0. The step still counts toward the P steps.
- R7: Each weight read in a step is XORed with `noise_mask & 8'h03` (the low NOISE_LSB = 2 bits). The upper mask bits have no effect.
- R8: While `energy_vld` is high and neither `start` nor `clr` is asserted, `energy` and `energy_vld` stay unchanged, whatever `sel`, `xfer_en` or `noise_mask` do.
- R9: `clr` high at an edge sets `energy` to 0 and `energy_vld` to 0 and stops any running evaluation. It takes priority over `start`.
- R10: The accumulator is 11 bits wide and holds the largest sum without wrapping. All weights 255 with `sel` = 8'h81 on three steps gives 1530.
- R11: A `start` during a running evaluation restarts it from zero with the step counter back at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Row write strobe |
| ld_row | input | 3 | Row index to write |
| ld_data | input | 24 | One byte per column, column 0 in the low byte |
| sel | input | 8 | Spin-derived row select, one bit per row |
| xfer_en | input | 1 | Cluster transfer enable for the current step |
| noise_mask | input | 8 | Bit-flip mask, only the low bits are applied |
| start | input | 1 | Begin a new evaluation |
| clr | input | 1 | Abort and zero the result |
| energy | output | 11 | Accumulated partial energy |
| energy_vld | output | 1 | Result complete and held |

## Verification
A wrong step counter or a wrong column index changes which weights are summed. That shows up in `energy` on the very next edge, because loaded rows are given a different value in every column. A wrong phase state, such as an extra or missing step, shows at the ports as `energy_vld` rising one cycle early or late, or as energy drifting while the result is meant to be held. The reference model is compared on every cycle, so any such error is reported in the cycle where it first appears.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
    localparam int unsigned CWE_P_DEF     = 3;
    localparam int unsigned CWE_WB_DEF    = 8;
    localparam int unsigned CWE_NLSB_DEF  = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/cwe_weight_window.sv
module cwe_weight_window #(
    parameter int unsigned P    = 3,
    parameter int unsigned WB   = 8,
    localparam int unsigned ROWS = 3 * P - 1,
    localparam int unsigned RW   = $clog2(ROWS),
    localparam int unsigned CW   = (P > 1) ? $clog2(P) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [RW-1:0]             ld_row,
    input  logic [P*WB-1:0]           ld_data,
    input  logic [CW-1:0]             rd_col,
    output logic [ROWS-1:0][WB-1:0]   rd_w
);
    logic [P-1:0][ROWS-1:0][WB-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (ld_en) begin
            for (int c = 0; c < P; c++) begin
                mem_d[c][ld_row] = ld_data[c*WB +: WB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rd_w = '0;
        for (int c = 0; c < P; c++) begin
            if (rd_col == CW'(c)) rd_w = mem_q[c];
        end
    end
endmodule

// File: rtl/cwe_pair_adder.sv
module cwe_pair_adder #(
    parameter int unsigned WB        = 8,
    parameter int unsigned ROWS      = 8,
    parameter int unsigned NOISE_LSB = 2
) (
    input  logic [ROWS-1:0][WB-1:0] col_w,
    input  logic [ROWS-1:0]         sel,
    input  logic                    xfer_en,
    input  logic [WB-1:0]           noise_mask,
    output logic [WB:0]             pair_sum
);
    localparam logic [WB-1:0] LSB_KEEP = WB'((1 << NOISE_LSB) - 1);

    logic [WB-1:0]            nmask;
    logic [ROWS-1:0]          sel_n;
    logic [ROWS-1:0][WB-1:0]  prod;

    assign nmask = noise_mask & LSB_KEEP;
    assign sel_n = ~sel;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [WB-1:0] bit_n;
        assign bit_n   = ~(col_w[r] ^ nmask);
        assign prod[r] = ~({WB{sel_n[r]}} | bit_n);
    end

    logic [$clog2(ROWS)-1:0] lo_idx, hi_idx;
    logic                    any_sel;

    always_comb begin
        lo_idx  = '0;
        hi_idx  = '0;
        any_sel = 1'b0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (sel[r]) lo_idx = $clog2(ROWS)'(r);
        end
        for (int r = 0; r < ROWS; r++) begin
            if (sel[r]) begin
                hi_idx  = $clog2(ROWS)'(r);
                any_sel = 1'b1;
            end
        end
    end

    always_comb begin
        pair_sum = '0;
        if (xfer_en && any_sel) begin
            if (lo_idx == hi_idx) pair_sum = {1'b0, prod[lo_idx]};
            else                  pair_sum = {1'b0, prod[lo_idx]} + {1'b0, prod[hi_idx]};
        end
    end

    always_comb begin
        if (sel == '0 || !xfer_en) begin
            AST_EMPTY_STEP: assert (pair_sum == '0); // R6
        end
    end
endmodule

// File: rtl/cwe_cluster_energy.sv
module cwe_cluster_energy
    import cwe_pkg::*;
#(
    parameter int unsigned P         = CWE_P_DEF,
    parameter int unsigned WB        = CWE_WB_DEF,
    parameter int unsigned NOISE_LSB = CWE_NLSB_DEF,
    localparam int unsigned ROWS  = 3 * P - 1,
    localparam int unsigned RW    = $clog2(ROWS),
    localparam int unsigned CW    = (P > 1) ? $clog2(P) : 1,
    localparam int unsigned ACC_W = $clog2(2 * P * ((1 << WB) - 1) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [RW-1:0]     ld_row,
    input  logic [P*WB-1:0]   ld_data,
    input  logic [ROWS-1:0]   sel,
    input  logic              xfer_en,
    input  logic [WB-1:0]     noise_mask,
    input  logic              start,
    input  logic              clr,
    output logic [ACC_W-1:0]  energy,
    output logic              energy_vld
);
    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   step;
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    logic [ROWS-1:0][WB-1:0] col_w;
    logic [WB:0]             pair_sum;

    cwe_weight_window #(.P(P), .WB(WB)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_row  (ld_row),
        .ld_data (ld_data),
        .rd_col  (st_q.step),
        .rd_w    (col_w)
    );

    cwe_pair_adder #(.WB(WB), .ROWS(ROWS), .NOISE_LSB(NOISE_LSB)) u_pair (
        .col_w      (col_w),
        .sel        (sel),
        .xfer_en    (xfer_en),
        .noise_mask (noise_mask),
        .pair_sum   (pair_sum)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ph   = PH_IDLE;
            st_d.step = '0;
            st_d.acc  = '0;
        end else if (start) begin
            st_d.ph   = PH_RUN;
            st_d.step = '0;
            st_d.acc  = '0;
        end else if (st_q.ph == PH_RUN) begin
            st_d.acc = st_q.acc + ACC_W'(pair_sum);
            if (st_q.step == CW'(P - 1)) begin
                st_d.ph   = PH_DONE;
                st_d.step = '0;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.step <= '0;
            st_q.acc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign energy     = st_q.acc;
    assign energy_vld = (st_q.ph == PH_DONE);

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr) |=> (energy == '0 && !energy_vld)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (energy == '0 && !energy_vld)); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (energy_vld && !start && !clr) |=> (energy_vld && $stable(energy))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && !start && !clr) |=> (energy >= $past(energy))); // R10
    AST_VLD_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(energy_vld) |-> $past(st_q.ph == PH_RUN)); // R3
endmodule

// File: tb/tb_cwe_cluster_energy.sv
module tb_cwe_cluster_energy;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_row = '0;
    logic [23:0] ld_data = '0;
    logic [7:0]  sel = '0;
    logic        xfer_en = 1'b1;
    logic [7:0]  noise_mask = '0;
    logic        start = 1'b0;
    logic        clr = 1'b0;
    logic [10:0] energy;
    logic        energy_vld;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    int wm [3][8];
    int m_acc = 0;
    int m_ph = 0;
    int m_step = 0;

    always #5 clk = ~clk;

    cwe_cluster_energy dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_data(ld_data),
        .sel(sel), .xfer_en(xfer_en), .noise_mask(noise_mask), .start(start), .clr(clr),
        .energy(energy), .energy_vld(energy_vld)
    );

    function automatic int step_sum(int col);
        int lo = -1;
        int hi = -1;
        int w_lo;
        int w_hi;
        for (int r = 0; r < 8; r++) begin
            if (sel[r]) begin
                if (lo < 0) lo = r;
                hi = r;
            end
        end
        if (!xfer_en || lo < 0) return 0;
        w_lo = wm[col][lo] ^ (noise_mask & 3);
        w_hi = wm[col][hi] ^ (noise_mask & 3);
        return (lo == hi) ? w_lo : w_lo + w_hi;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_ph = 0; m_step = 0;
            for (int c = 0; c < 3; c++)
                for (int r = 0; r < 8; r++) wm[c][r] = 0;
        end else begin
            if (clr) begin
                m_acc = 0; m_ph = 0; m_step = 0;
            end else if (start) begin
                m_acc = 0; m_ph = 1; m_step = 0;
            end else if (m_ph == 1) begin
                m_acc = m_acc + step_sum(m_step);
                if (m_step == 2) begin m_ph = 2; m_step = 0; end
                else m_step = m_step + 1;
            end
            if (ld_en)
                for (int c = 0; c < 3; c++) wm[c][ld_row] = int'(ld_data[c*8 +: 8]);
        end
    end

    task automatic check(string t, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic compare();
        check({tag, " energy"}, int'(energy), m_acc);
        check({tag, " valid"}, int'(energy_vld), (m_ph == 2) ? 1 : 0);
    endtask

    task automatic tick(logic [7:0] s, logic x, logic [7:0] m, logic st, logic cl);
        @(negedge clk);
        compare();
        sel = s; xfer_en = x; noise_mask = m; start = st; clr = cl; ld_en = 1'b0;
    endtask

    task automatic load_row(int r, logic [23:0] d, logic [7:0] s);
        @(negedge clk);
        compare();
        ld_en = 1'b1; ld_row = 3'(r); ld_data = d; start = 1'b0; clr = 1'b0; sel = s;
    endtask

    task automatic run3(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] m);
        tick(8'h00, 1'b1, m, 1'b1, 1'b0);
        tick(a, 1'b1, m, 1'b0, 1'b0);
        tick(b, 1'b1, m, 1'b0, 1'b0);
        tick(c, 1'b1, m, 1'b0, 1'b0);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        tag = "R1";
        check("R1 reset energy", int'(energy), 0);
        check("R1 reset valid", int'(energy_vld), 0);
        rst_n = 1'b1;
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        tag = "R1";
        run3(8'h03, 8'h81, 8'hFF, 8'h00);   // stored zeros give zero
        tag = "R2";
        for (int r = 0; r < 8; r++)
            load_row(r, {8'(r*7+100), 8'(r*29+50), 8'(r*17+3)}, 8'h00);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        tag = "R4";
        run3(8'h05, 8'h30, 8'h82, 8'h00);
        run3(8'h10, 8'h00, 8'h01, 8'h00);
        tag = "R5";
        run3(8'hFF, 8'h7E, 8'h1C, 8'h00);
        tag = "R6";
        tick(8'h00, 1'b1, 8'h00, 1'b1, 1'b0);
        tick(8'h11, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h11, 1'b0, 8'h00, 1'b0, 1'b0);
        tick(8'h11, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        tag = "R7";
        run3(8'h06, 8'h09, 8'h41, 8'hFF);
        run3(8'h06, 8'h09, 8'h41, 8'hFC);
        tag = "R8";
        for (int k = 0; k < 5; k++) tick(8'(k*37+1), k[0], 8'hFF, 1'b0, 1'b0);
        tag = "R2";
        tick(8'h00, 1'b1, 8'h00, 1'b1, 1'b0);
        load_row(0, 24'hFFFFFF, 8'h03);       // step reads old row 0
        tick(8'h03, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h03, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        tag = "R9";
        tick(8'h00, 1'b1, 8'h00, 1'b1, 1'b0);
        tick(8'h21, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h21, 1'b1, 8'h00, 1'b0, 1'b1);
        tick(8'h21, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h21, 1'b1, 8'h00, 1'b1, 1'b1);
        tick(8'h21, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        tag = "R11";
        tick(8'h00, 1'b1, 8'h00, 1'b1, 1'b0);
        tick(8'h0C, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h0C, 1'b1, 8'h00, 1'b1, 1'b0);
        tick(8'h44, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h22, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h88, 1'b1, 8'h00, 1'b0, 1'b0);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        tag = "R10";
        for (int r = 0; r < 8; r++) load_row(r, 24'hFFFFFF, 8'h00);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        run3(8'h81, 8'h81, 8'h81, 8'h00);
        check("R10 full-scale energy", int'(energy), 1530);
        check("R10 full-scale valid", int'(energy_vld), 1);
        tick(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule